// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Generator

This block raises the transmitter-empty interrupt of a UART whose transmit FIFO holds sixteen entries. It watches the FIFO occupancy, the CPU strobes for writing the holding register and reading the interrupt identification register, a baud-rate tick and the character format. From these it keeps a pending latch and drives an interrupt request together with a four-bit identification code. The FIFO storage and the serializer are elsewhere; this block only sees their occupancy.

When the FIFO drains after it has held two or more characters at the same time, the pending latch is set at once. When it drains after only ever holding single characters, the latch is held back by one character time minus the final stop bit, measured in baud ticks, so that a CPU feeding one byte at a time is not interrupted on every byte. A change of the FIFO-enable bit while the FIFO is empty sets the latch immediately. With the enable for this interrupt cleared, the empty status stays readable for polled operation.

Top module: `uart_thre_irq`

## Requirements
- R1: After reset `irq` is 0 and `iid` is 4'h1 (nothing pending), and no interrupt appears afterwards without a new event.
- R2: `thre` is 1 exactly when `fifo_count` is 0, whatever the enable inputs are.
- R3: `irq` is 1 only when the latch is pending, `fifo_en` is 1 and `tx_ie` is 1; `iid` is 4'h2 while `irq` is 1 and 4'h1 otherwise.
- R4: A cycle with `thr_wr` high clears the pending latch at that clock edge, taking priority over every set event.
- R5: A cycle with `iir_rd` high clears the pending latch at that edge unless a set event occurs in the same cycle.
- R6: If occupancy reached 2 or more since the last empty event, the latch is set at the first edge at which `fifo_count` is sampled as 0.
- R7: Otherwise the latch is set at the edge of the D-th baud tick after that first empty edge, with D = (5 + `word_len`) + `parity_en` + 1 + `two_stop`.
- R8: A pending hold-back is abandoned, without setting the latch, if `thr_wr` is high or `fifo_count` is nonzero before it expires; a later empty event starts a new one.
- R9: A change of `fifo_en` sampled while `fifo_count` is 0 sets the latch at that edge; a change while the FIFO holds data does not.
- R10: Lowering `tx_ie` hides the request but keeps the latch; raising it again brings `irq` back.
- R11: The record of having held two or more bytes clears at each empty event, so the next empty event after single-byte traffic is held back again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | One-cycle strobe: CPU write to the holding register |
| iir_rd | input | 1 | One-cycle strobe: CPU read of the identification register |
| baud_tick | input | 1 | One pulse per bit time |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Second stop bit present |
| fifo_en | input | 1 | FIFO-enable control bit |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| thre | output | 1 | Transmit FIFO empty status |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Identification code: 4'h2 pending, 4'h1 none |

## Verification
The drain path is swept over all sixteen character formats with three fill histories: single-byte traffic, a two-byte peak, and single-byte traffic right after a two-byte peak, so that an immediate interrupt, a held-back one and a wrongly retained fill record each produce a distinct edge count. The hold-back is also paced by sparse baud ticks to separate counting ticks from counting clocks, and it is broken by a write and by refilled occupancy to show the abort. Enable toggles with an empty and with an occupied FIFO separate the control-change event from plain masking, and an occupancy sweep from 0 to 16 under both interrupt-enable settings pins the status flag.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;

    parameter int TX_DEPTH = 16;
    localparam int OCC_W   = $clog2(TX_DEPTH + 1);
    localparam int DLY_W   = 4;

    typedef struct packed {
        logic [1:0] word_len;
        logic       parity_en;
        logic       two_stop;
    } char_cfg_t;

    typedef struct packed {
        logic now;
        logic held;
        logic ctrl;
    } thre_evt_t;

    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_THRE = 4'h2
    } iid_e;

    // Bit times of one frame without its final stop bit:
    // start + data + parity + (extra stop when two are configured).
    function automatic logic [DLY_W-1:0] hold_ticks(char_cfg_t c);
        logic [DLY_W-1:0] r;
        r = DLY_W'(6) + DLY_W'(c.word_len) + DLY_W'(c.parity_en) + DLY_W'(c.two_stop);
        return r;
    endfunction

endpackage

// File: rtl/thre_fill_track.sv
module thre_fill_track #(
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] fifo_count,
    output logic             empty,
    output logic             empty_rise,
    output logic             seen_two
);
    logic empty_q;

    assign empty      = (fifo_count == '0);
    assign empty_rise = empty & ~empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q  <= 1'b1;
            seen_two <= 1'b0;
        end else begin
            empty_q <= empty;
            if (empty_rise)
                seen_two <= 1'b0;
            else if (fifo_count >= OCC_W'(2))
                seen_two <= 1'b1;
        end
    end

    assert_fill_record_cleared_R11: assert property (
        @(posedge clk) disable iff (rst) empty_rise |=> !seen_two);

endmodule

// File: rtl/thre_hold_timer.sv
module thre_hold_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             empty,
    input  logic             abort,
    input  logic             tick,
    input  logic [DLY_W-1:0] load,
    output logic             fire
);
    logic             busy;
    logic [DLY_W-1:0] cnt;

    assign fire = busy & empty & ~abort & tick & (cnt == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy) begin
            if (abort || !empty) begin
                busy <= 1'b0;
            end else if (tick) begin
                if (cnt == DLY_W'(1))
                    busy <= 1'b0;
                else
                    cnt <= cnt - DLY_W'(1);
            end
        end
    end

    assert_write_aborts_hold_R8: assert property (
        @(posedge clk) disable iff (rst) (busy && abort && !start) |=> !busy);

    assert_hold_waits_for_tick_R7: assert property (
        @(posedge clk) disable iff (rst)
        (busy && !tick && !abort && empty && !start) |=> (busy && $stable(cnt)));

endmodule

// File: rtl/thre_pend_latch.sv
module thre_pend_latch
    import uart_thre_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      empty,
    input  thre_evt_t evt_in,
    input  logic      thr_wr,
    input  logic      iir_rd,
    output logic      pend
);
    logic      fifo_en_q;
    thre_evt_t evt;
    logic      set_any;

    always_comb begin
        evt      = evt_in;
        evt.ctrl = (fifo_en ^ fifo_en_q) & empty;
        set_any  = evt.now | evt.held | evt.ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en_q <= fifo_en;
            pend      <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
            if (thr_wr)
                pend <= 1'b0;
            else if (set_any)
                pend <= 1'b1;
            else if (iir_rd)
                pend <= 1'b0;
        end
    end

    assert_write_clears_R4: assert property (
        @(posedge clk) disable iff (rst) thr_wr |=> !pend);

    assert_read_clears_R5: assert property (
        @(posedge clk) disable iff (rst) (iir_rd && !set_any) |=> !pend);

endmodule

// File: rtl/uart_thre_irq.sv
module uart_thre_irq
    import uart_thre_pkg::*;
#(
    parameter int FIFO_DEPTH = uart_thre_pkg::TX_DEPTH,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             baud_tick,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    input  logic             fifo_en,
    input  logic             tx_ie,
    output logic             thre,
    output logic             irq,
    output logic [3:0]       iid
);
    char_cfg_t        cfg;
    thre_evt_t        evt;
    logic             empty;
    logic             empty_rise;
    logic             seen_two;
    logic             hold_fire;
    logic             pend;
    logic [DLY_W-1:0] hold_len;

    assign cfg      = '{word_len: word_len, parity_en: parity_en, two_stop: two_stop};
    assign hold_len = hold_ticks(cfg);

    thre_fill_track #(.OCC_W(CNT_W)) fill_i (
        .clk        (clk),
        .rst        (rst),
        .fifo_count (fifo_count),
        .empty      (empty),
        .empty_rise (empty_rise),
        .seen_two   (seen_two)
    );

    thre_hold_timer #(.DLY_W(DLY_W)) hold_i (
        .clk   (clk),
        .rst   (rst),
        .start (empty_rise & ~seen_two & ~thr_wr),
        .empty (empty),
        .abort (thr_wr),
        .tick  (baud_tick),
        .load  (hold_len),
        .fire  (hold_fire)
    );

    assign evt = '{now: empty_rise & seen_two, held: hold_fire, ctrl: 1'b0};

    thre_pend_latch pend_i (
        .clk    (clk),
        .rst    (rst),
        .fifo_en(fifo_en),
        .empty  (empty),
        .evt_in (evt),
        .thr_wr (thr_wr),
        .iir_rd (iir_rd),
        .pend   (pend)
    );

    assign thre = empty;
    assign irq  = pend & fifo_en & tx_ie;
    assign iid  = irq ? IID_THRE : IID_NONE;

    assert_drain_after_peak_R6: assert property (
        @(posedge clk) disable iff (rst)
        (empty_rise && seen_two && !thr_wr) |=> pend);

    assert_mask_keeps_latch_R10: assert property (
        @(posedge clk) disable iff (rst)
        (pend && !thr_wr && !iir_rd) |=> pend);

endmodule

// File: tb/uart_thre_irq_tb_top.sv
module uart_thre_irq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] fifo_count;
    logic       thr_wr, iir_rd, baud_tick;
    logic [1:0] word_len;
    logic       parity_en, two_stop, fifo_en, tx_ie;
    logic       thre, irq;
    logic [3:0] iid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_thre_irq dut_i (
        .clk(clk), .rst(rst), .fifo_count(fifo_count), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .baud_tick(baud_tick), .word_len(word_len),
        .parity_en(parity_en), .two_stop(two_stop), .fifo_en(fifo_en),
        .tx_ie(tx_ie), .thre(thre), .irq(irq), .iid(iid)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_pend();
        iir_rd = 1'b1;
        step();
        iir_rd = 1'b0;
    endtask

    task automatic push(int n);
        fifo_count = 5'(n);
        thr_wr = 1'b1;
        step();
        thr_wr = 1'b0;
    endtask

    // Drain the FIFO and count edges until irq shows.
    task automatic drain_measure(output int n);
        logic found;
        found = 1'b0;
        n = 0;
        fifo_count = 5'd0;
        for (int i = 1; i <= 40; i++) begin
            if (!found) begin
                step();
                if (irq) begin
                    found = 1'b1;
                    n = i;
                end
            end
        end
    endtask

    function automatic int exp_hold(int wl, int p, int s);
        return (5 + wl) + p + 1 + s;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        int d;
        rst = 1'b1; fifo_count = 5'd0; thr_wr = 1'b0; iir_rd = 1'b0;
        baud_tick = 1'b1; word_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
        fifo_en = 1'b1; tx_ie = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 iid in reset", int'(iid), 1);
        rst = 1'b0;
        repeat (4) step();
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 iid after reset", int'(iid), 1);

        // Format sweep: held-back, immediate, record cleared.
        for (int wl = 0; wl < 4; wl++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 2; s++) begin
                    word_len = 2'(wl); parity_en = 1'(p); two_stop = 1'(s);
                    d = exp_hold(wl, p, s);
                    push(1);
                    step();
                    drain_measure(n);
                    chk("R7 held-back edge count", n, d + 1);
                    clear_pend();
                    chk("R5 read clears", int'(irq), 0);
                    push(1);
                    push(2);
                    drain_measure(n);
                    chk("R6 immediate edge count", n, 1);
                    clear_pend();
                    push(1);
                    drain_measure(n);
                    chk("R11 record cleared edge count", n, d + 1);
                    clear_pend();
                end
            end
        end

        // Abort paths with an 11-tick hold.
        word_len = 2'd3; parity_en = 1'b1; two_stop = 1'b1;
        d = exp_hold(3, 1, 1);
        push(1);
        fifo_count = 5'd0;
        step(); step();
        push(1);
        repeat (20) step();
        chk("R8 write aborts hold", int'(irq), 0);
        fifo_count = 5'd0;
        step(); step();
        fifo_count = 5'd1;
        repeat (20) step();
        chk("R8 refill aborts hold", int'(irq), 0);
        drain_measure(n);
        chk("R8 new hold after abort", n, d + 1);

        // Write clears a pending request.
        push(1);
        chk("R4 write clears", int'(irq), 0);

        // Sparse ticks: the hold counts ticks, not clocks.
        baud_tick = 1'b0;
        fifo_count = 5'd0;
        step();
        for (int i = 1; i <= d; i++) begin
            chk("R7 no irq before last tick", int'(irq), 0);
            baud_tick = 1'b1;
            step();
            baud_tick = 1'b0;
            step();
        end
        chk("R7 irq after last tick", int'(irq), 1);
        baud_tick = 1'b1;
        clear_pend();

        // Mask with tx_ie.
        push(2);
        drain_measure(n);
        chk("R6 pending for mask test", n, 1);
        tx_ie = 1'b0;
        step();
        chk("R10 irq masked", int'(irq), 0);
        chk("R3 iid when masked", int'(iid), 1);
        chk("R2 thre visible when masked", int'(thre), 1);
        tx_ie = 1'b1;
        step();
        chk("R10 irq returns", int'(irq), 1);
        chk("R3 iid when pending", int'(iid), 2);
        clear_pend();

        // FIFO-enable changes.
        fifo_en = 1'b0;
        step();
        chk("R3 irq off while fifo disabled", int'(irq), 0);
        clear_pend();
        fifo_en = 1'b1;
        step();
        chk("R9 enable change sets irq", int'(irq), 1);
        clear_pend();
        chk("R5 read clears after enable change", int'(irq), 0);
        push(1);
        fifo_en = 1'b0;
        step();
        fifo_en = 1'b1;
        step();
        chk("R9 no event while occupied", int'(irq), 0);
        drain_measure(n);
        chk("R9 occupied toggle leaves hold", n, d + 1);
        clear_pend();

        // Status flag over every occupancy.
        for (int ie = 0; ie < 2; ie++) begin
            tx_ie = 1'(ie);
            for (int c = 0; c <= 16; c++) begin
                fifo_count = 5'(c);
                step();
                chk("R2 thre versus occupancy", int'(thre), (c == 0) ? 1 : 0);
            end
        end
        tx_ie = 1'b1;

        summary();
        $finish;
    end
endmodule